// File: doc/BRIEF.md
# Self-correcting twisted-ring counter with phase decoder

This block is an N-stage shift register whose input stage receives the inverted output of its last stage. Starting from all zeros, the register fills with ones from the input end and then drains them. The result is a main loop of 2N states. Each state in that loop is decoded into one of 2N phase lines, and exactly one line is active at a time. A typical use is a divider or sequencer that needs glitch-free decoded phases. With N = 5 it forms a decade sequencer with ten phase lines.

An upset, or an undefined power-up value, can leave the register holding a pattern that lies outside the main loop. Without help, such a pattern would circulate forever in a parasitic loop. For odd N this includes the length-2 loop formed by the two alternating-bit patterns. The block checks every state against the main-loop shape. When it finds a state outside that shape, it clears the register to all zeros on the next edge and raises a one-cycle correction pulse. A synchronous seed port can load any pattern, so that all 2^N states can be exercised. The seed port is a plain control pin with no handshake.

Top module: `twr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the register loads all zeros and `recover_pulse` is low after that edge.
- R2: In a valid state, with `rst` and `seed_en` low, each edge shifts the register toward its most significant bit (bit N-1 is the last stage), and the new bit 0 is the inverse of the old bit N-1.
- R3: Starting from all zeros, the register passes through 2N distinct states and returns to all zeros after exactly 2N edges.
- R4: A state is valid when its adjacent bit pairs differ in at most one place, which means the state holds one contiguous run of ones or of zeros. Exactly 2N of the 2^N states are valid.
- R5: In an invalid state, with `rst` and `seed_en` low, the next edge loads all zeros and sets `recover_pulse` high for the following cycle.
- R6: `recover_pulse` is never high on two consecutive cycles unless an invalid seed is loaded in between.
- R7: For odd N, both alternating patterns are invalid and are corrected. The low one has value (2^N-2)/3, for example 01010 for N = 5, and the other is its complement.
- R8: In a valid state, exactly one bit of `phase_oh` is high. Its index is popcount(state) when bit N-1 is 0, and 2N-popcount(state) when bit N-1 is 1.
- R9: In an invalid state, `phase_oh` is all zeros.
- R10: With `rst` low and `seed_en` high, the next edge loads `seed_val` and leaves `recover_pulse` low. `rst` takes priority over `seed_en`.
- R11: From any loaded state, the register holds a valid state at most two edges after `seed_en` drops, and it then repeats with period 2N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to all zeros |
| seed_en | input | 1 | Load `seed_val` into the register on the next edge |
| seed_val | input | STAGES | Pattern to load |
| ring_q | output | STAGES | Register contents, bit 0 is the input stage |
| phase_oh | output | 2*STAGES | One-hot decoded phase |
| recover_pulse | output | 1 | High for one cycle after an invalid state was cleared |

## Verification
A wrong internal state shows at the ports in one of two ways. It may appear as a register value that breaks the shape rule, in which case `phase_oh` goes all zeros in that same cycle. Or it may appear as a valid but out-of-order value, in which case the next `ring_q` differs from the shifted-and-inverted prediction one edge later. The bench seeds every one of the 2^N patterns, including the alternating ones for odd N, and compares `ring_q`, `phase_oh` and `recover_pulse` with a behavioural model on every clock. A missed correction therefore surfaces within one edge. An error in the loop length surfaces within 2N edges.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [1:0] {
    ACT_SHIFT = 2'd0,
    ACT_SEED  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_RESET = 2'd3
  } twr_act_e;
endpackage

// File: rtl/twr_shape_check.sv
module twr_shape_check #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] bits_i,
  output logic              well_formed_o
);
  localparam int CW = $clog2(STAGES) + 1;

  logic [STAGES-2:0] edge_v;
  logic [CW-1:0]     edge_cnt;

  genvar g;
  generate
    for (g = 0; g < STAGES - 1; g++) begin : g_edge
      assign edge_v[g] = bits_i[g+1] ^ bits_i[g];
    end
  endgenerate

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < STAGES - 1; i++) begin
      edge_cnt = edge_cnt + CW'(edge_v[i]);
    end
  end

  assign well_formed_o = (edge_cnt <= CW'(1));
endmodule

// File: rtl/twr_decode.sv
module twr_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   bits_i,
  input  logic                well_formed_i,
  output logic [2*STAGES-1:0] phase_o
);
  localparam int PHASES = 2 * STAGES;

  logic [PHASES-1:0] raw;

  assign raw[0]      = ~bits_i[STAGES-1] & ~bits_i[0];
  assign raw[STAGES] =  bits_i[STAGES-1] &  bits_i[0];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_pair
      assign raw[k]          =  bits_i[k-1] & ~bits_i[k];
      assign raw[STAGES + k] = ~bits_i[k-1] &  bits_i[k];
    end
  endgenerate

  assign phase_o = well_formed_i ? raw : '0;
endmodule

// File: rtl/twr_state.sv
module twr_state
  import twr_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_en,
  input  logic [STAGES-1:0] seed_val,
  input  logic              well_formed_i,
  output logic [STAGES-1:0] q_o,
  output logic              recover_o
);
  twr_act_e          act;
  logic [STAGES-1:0] q_next;

  always_comb begin
    if (rst)                 act = ACT_RESET;
    else if (seed_en)        act = ACT_SEED;
    else if (!well_formed_i) act = ACT_CLEAR;
    else                     act = ACT_SHIFT;
  end

  always_comb begin
    case (act)
      ACT_SEED:  q_next = seed_val;
      ACT_SHIFT: q_next = {q_o[STAGES-2:0], ~q_o[STAGES-1]};
      default:   q_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    q_o       <= q_next;
    recover_o <= (act == ACT_CLEAR);
  end
endmodule

// File: rtl/twr_counter.sv
module twr_counter #(
  parameter int STAGES = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                seed_en,
  input  logic [STAGES-1:0]   seed_val,
  output logic [STAGES-1:0]   ring_q,
  output logic [2*STAGES-1:0] phase_oh,
  output logic                recover_pulse
);
  logic shape_ok;

  twr_shape_check #(.STAGES(STAGES)) u_shape (
    .bits_i        (ring_q),
    .well_formed_o (shape_ok)
  );

  twr_state #(.STAGES(STAGES)) u_state (
    .clk           (clk),
    .rst           (rst),
    .seed_en       (seed_en),
    .seed_val      (seed_val),
    .well_formed_i (shape_ok),
    .q_o           (ring_q),
    .recover_o     (recover_pulse)
  );

  twr_decode #(.STAGES(STAGES)) u_decode (
    .bits_i        (ring_q),
    .well_formed_i (shape_ok),
    .phase_o       (phase_oh)
  );
endmodule

// File: rtl/twr_counter_chk.sv
module twr_counter_chk #(
  parameter int STAGES = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                seed_en,
  input logic [STAGES-1:0]   seed_val,
  input logic [STAGES-1:0]   ring_q,
  input logic [2*STAGES-1:0] phase_oh,
  input logic                recover_pulse
);
  localparam int PHASES = 2 * STAGES;

  logic [STAGES-1:0] inv_q;
  logic              in_loop;
  logic [PHASES-1:0] want_phase;
  int                pop;

  assign inv_q   = ~ring_q;
  assign in_loop = ((ring_q & (ring_q + 1'b1)) == '0) || ((inv_q & (inv_q + 1'b1)) == '0);

  always_comb begin
    pop = $countones(ring_q);
    want_phase = '0;
    if (in_loop) begin
      if (ring_q[STAGES-1]) want_phase[PHASES - pop] = 1'b1;
      else                  want_phase[pop] = 1'b1;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (ring_q == '0) && !recover_pulse);

  assert_shift_invert_R2: assert property (@(posedge clk) disable iff (rst)
    (!seed_en && in_loop) |=> ring_q == {$past(ring_q[STAGES-2:0]), ~$past(ring_q[STAGES-1])});

  assert_clear_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    (!seed_en && !in_loop) |=> (ring_q == '0) && recover_pulse);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    recover_pulse |=> !recover_pulse);

  assert_phase_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_oh) && (phase_oh == want_phase));

  assert_invalid_dark_R9: assert property (@(posedge clk) disable iff (rst)
    !in_loop |-> (phase_oh == '0));

  assert_seed_load_R10: assert property (@(posedge clk) disable iff (rst)
    seed_en |=> (ring_q == $past(seed_val)) && !recover_pulse);
endmodule

bind twr_counter twr_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .seed_en       (seed_en),
  .seed_val      (seed_val),
  .ring_q        (ring_q),
  .phase_oh      (phase_oh),
  .recover_pulse (recover_pulse)
);

// File: tb/test_twr_counter.sv
`timescale 1ns/1ps
module test_twr_counter;
  localparam int N      = 5;
  localparam int PH     = 2 * N;
  localparam int STATES = 1 << N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          seed_en = 1'b0;
  logic [N-1:0]  seed_val = '0;
  logic [N-1:0]  ring_q;
  logic [PH-1:0] phase_oh;
  logic          recover_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  logic [N-1:0] m_q;
  logic         m_fix;

  always #2 clk = ~clk;

  twr_counter #(.STAGES(N)) i_twr_counter (
    .clk(clk), .rst(rst), .seed_en(seed_en), .seed_val(seed_val),
    .ring_q(ring_q), .phase_oh(phase_oh), .recover_pulse(recover_pulse)
  );

  function automatic bit ref_valid(input logic [N-1:0] v);
    int t = 0;
    for (int i = 0; i < N - 1; i++) if (v[i] != v[i+1]) t++;
    return t <= 1;
  endfunction

  function automatic logic [PH-1:0] ref_phase(input logic [N-1:0] v);
    logic [PH-1:0] r = '0;
    int p = 0;
    for (int i = 0; i < N; i++) if (v[i]) p++;
    if (ref_valid(v)) begin
      if (v[N-1]) r[PH - p] = 1'b1;
      else        r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst)                  begin m_q = '0;       m_fix = 1'b0; end
    else if (seed_en)         begin m_q = seed_val; m_fix = 1'b0; end
    else if (!ref_valid(m_q)) begin m_q = '0;       m_fix = 1'b1; end
    else begin m_q = {m_q[N-2:0], ~m_q[N-1]}; m_fix = 1'b0; end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(ring_q == m_q, "R2/R5 state", int'(ring_q), int'(m_q));
      check(phase_oh == ref_phase(m_q), "R8/R9 phase", int'(phase_oh), int'(ref_phase(m_q)));
      check(recover_pulse == m_fix, "R5/R6 pulse", int'(recover_pulse), int'(m_fix));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  initial begin
    logic [N-1:0] ref0;
    logic [N-1:0] alt_lo;
    int valid_seen = 0;
    bit zero_early;

    repeat (3) @(negedge clk);
    check(ring_q == '0 && !recover_pulse, "R1 reset", int'(ring_q), 0);
    cmp_on = 1'b1;
    rst = 1'b0;

    // R3: loop from zero returns after exactly 2N edges
    zero_early = 1'b0;
    for (int i = 1; i < PH; i++) begin
      @(negedge clk);
      if (ring_q == '0) zero_early = 1'b1;
    end
    @(negedge clk);
    check(!zero_early && ring_q == '0, "R3 loop length", int'(ring_q), 0);

    // Sweep every pattern through the seed port
    for (int s = 0; s < STATES; s++) begin
      seed_en  = 1'b1;
      seed_val = N'(s);
      @(negedge clk);
      seed_en = 1'b0;
      check(ring_q == N'(s), "R10 seed load", int'(ring_q), s);
      if (phase_oh != '0) valid_seen++;
      @(negedge clk);
      if (!ref_valid(N'(s)))
        check(recover_pulse && ring_q == '0, "R5 clear", int'(ring_q), 0);
      @(negedge clk);
      check(phase_oh != '0, "R11 entry", int'(ring_q), 0);
      ref0 = ring_q;
      repeat (PH) @(negedge clk);
      check(ring_q == ref0, "R11 period", int'(ring_q), int'(ref0));
    end
    check(valid_seen == PH, "R4 valid count", valid_seen, PH);

    // R7: alternating patterns for odd N
    if (N % 2 == 1) begin
      alt_lo = N'(((1 << N) - 2) / 3);
      for (int k = 0; k < 2; k++) begin
        seed_en  = 1'b1;
        seed_val = (k == 0) ? alt_lo : ~alt_lo;
        @(negedge clk);
        seed_en = 1'b0;
        check(phase_oh == '0, "R7 alt dark", int'(phase_oh), 0);
        @(negedge clk);
        check(recover_pulse && ring_q == '0, "R7 alt clear", int'(ring_q), 0);
        @(negedge clk);
        check(!recover_pulse, "R6 pulse width", int'(recover_pulse), 0);
      end
    end

    // R10: reset beats seed
    rst = 1'b1;
    seed_en = 1'b1;
    seed_val = N'(3);
    @(negedge clk);
    check(ring_q == '0, "R10 reset priority", int'(ring_q), 0);
    rst = 1'b0;
    seed_en = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule